// File: doc/BRIEF.md
# SPI Serial-Clock Divider with Linear and Power-of-Two Modes

This block derives the serial clock of an SPI master from its module clock. One control word holds two separate divider fields and a select bit. The linear setting gives an even divisor from 2 up to 512. The power-of-two setting gives divisors up to 65536, so it covers rates that the linear setting cannot reach. The serial clock always has a 50% duty cycle, because each half period lasts the same whole number of module clocks.

A transfer engine raises `run` for the length of a burst. While `run` is low, the half-period counter is held at zero, the serial clock rests at the idle polarity, and the control word is copied into a shadow register. During a burst the divider uses only the shadow copy, so a new control value written mid-burst takes effect at the next idle period. Each serial-clock toggle also produces a one-cycle strobe. The strobe is marked leading (away from the idle level) or trailing (back to it), so the shifter can apply either clock phase.

Top module: `sclk_divgen`

## Requirements
- R1: During reset and on the first cycle after it, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: On every clock edge where `run` is low, `sclk` takes the value of `cpol`, the counter returns to zero and no strobe is issued. Both values are visible in the following cycle.
- R3: When `clk_ctl[12]` = 1 (linear), the half period is N+1 module clocks, where N = `clk_ctl[7:0]`. The full serial period is therefore 2×(N+1).
- R4: When `clk_ctl[12]` = 0 (power-of-two), the half period is 2^M module clocks, where M = `clk_ctl[11:8]`. The full period is therefore 2^(M+1).
- R5: Counting starts on the first clock edge at which `run` is high. The first toggle appears H cycles after `run` rises, where H is the half period.
- R6: Every toggle during a burst is marked by exactly one one-cycle strobe, issued in the same cycle as the new `sclk` level. `lead_stb` marks a toggle away from the idle level and `trail_stb` marks a toggle back to it. The two strobes are never high together.
- R7: A change to `clk_ctl` or `cpol` while `run` is high does not affect the current burst. The value present at the last idle edge is used, and the new value takes effect after `run` has been low for at least one edge.
- R8: The extreme settings are exact: N=0 gives a period of 2, N=255 gives a period of 512, and M=15 gives a first toggle after 32768 cycles.
- R9: Dropping `run` in the middle of a half period returns `sclk` to idle on the next edge. The following burst then starts counting again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] 1 = linear, 0 = power-of-two |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | Burst in progress, driven by the transfer engine |
| sclk | output | 1 | Serial clock, 50% duty |
| lead_stb | output | 1 | One-cycle strobe on a toggle away from the idle level |
| trail_stb | output | 1 | One-cycle strobe on a toggle back to the idle level |

## Verification
A corrupted counter or terminal value shows at the ports as a toggle that comes one or more cycles early or late. The per-cycle comparison against the bench model flags it at the first misplaced edge, which is at most one half period after the fault. A wrong shadow update, such as capturing the control word mid-burst, changes the toggle spacing within the same burst. A wrong lead/trail decision or a stuck idle level shows on the very next toggle or idle cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
    parameter int unsigned LIN_W = 8;
    parameter int unsigned EXP_W = 4;
    // Terminal count is (half period - 1): linear needs LIN_W bits, power-of-two needs 2**EXP_W - 1 bits
    localparam int unsigned CNT_W = ((2 ** EXP_W) - 1 > LIN_W) ? (2 ** EXP_W) - 1 : LIN_W;
    localparam int unsigned CTL_W = LIN_W + EXP_W + 1;

    // Field order fixes the positions software writes: select on top, exponent above linear
    typedef struct packed {
        logic             lin_sel;
        logic [EXP_W-1:0] exp_m;
        logic [LIN_W-1:0] lin_n;
    } clk_ctl_t;

    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/sclk_cfg_shadow.sv
module sclk_cfg_shadow
    import sclk_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_ctl_t ctl_in,
    input  logic     cpol_in,
    output clk_ctl_t ctl_o,
    output logic     pol_o
);
    typedef struct packed {
        clk_ctl_t ctl;
        logic     pol;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!run) begin
            sh_d.ctl = ctl_in;
            sh_d.pol = cpol_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ctl_o = sh_q.ctl;
    assign pol_o = sh_q.pol;
endmodule

// File: rtl/sclk_half_decode.sv
module sclk_half_decode
    import sclk_div_pkg::*;
(
    input  clk_ctl_t ctl,
    output cnt_t     term
);
    localparam cnt_t ONE = cnt_t'(1);

    always_comb begin
        if (ctl.lin_sel) term = cnt_t'(ctl.lin_n);
        else             term = (ONE << ctl.exp_m) - ONE;
    end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
    import sclk_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  cnt_t term,
    input  logic idle_pol,
    input  logic cpol_live,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);
    typedef struct packed {
        cnt_t cnt;
        logic sclk;
        logic lead;
        logic trail;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d       = g_q;
        g_d.lead  = 1'b0;
        g_d.trail = 1'b0;
        if (!run) begin
            g_d.cnt  = '0;
            g_d.sclk = cpol_live;
        end else if (g_q.cnt == term) begin
            g_d.cnt   = '0;
            g_d.sclk  = ~g_q.sclk;
            g_d.lead  = (g_q.sclk == idle_pol);
            g_d.trail = (g_q.sclk != idle_pol);
        end else begin
            g_d.cnt = g_q.cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk      = g_q.sclk;
    assign lead_stb  = g_q.lead;
    assign trail_stb = g_q.trail;
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] clk_ctl,
    input  logic             cpol,
    input  logic             run,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    clk_ctl_t ctl_sh;
    logic     pol_sh;
    cnt_t     term;

    sclk_cfg_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ctl_in  (clk_ctl_t'(clk_ctl)),
        .cpol_in (cpol),
        .ctl_o   (ctl_sh),
        .pol_o   (pol_sh)
    );

    sclk_half_decode u_decode (
        .ctl  (ctl_sh),
        .term (term)
    );

    sclk_edge_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .term      (term),
        .idle_pol  (pol_sh),
        .cpol_live (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );
endmodule

// File: rtl/sclk_divgen_chk.sv
module sclk_divgen_chk (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic run,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R6: leading and trailing strobes exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R6: a strobe always accompanies a change of level
    a_r6_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

    // R6: any toggle made while running carries a strobe
    a_r6_toggle_strobed: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(run) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

    // R2: idle edge forces idle level and quiet strobes
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);
endmodule

bind sclk_divgen sclk_divgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpol      (cpol),
    .run       (run),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/sclk_divgen_test.sv
module sclk_divgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] clk_ctl = '0;
    logic        cpol = 1'b0;
    logic        run = 1'b0;
    logic        sclk, lead_stb, trail_stb;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    sclk_divgen uut (
        .clk(clk), .rst_n(rst_n), .clk_ctl(clk_ctl), .cpol(cpol), .run(run),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    function automatic logic [12:0] lin_cfg(int n);
        return {1'b1, 4'd0, 8'(n)};
    endfunction
    function automatic logic [12:0] exp_cfg(int m);
        return {1'b0, 4'(m), 8'd0};
    endfunction

    // Behavioural reference: configuration held in integers, half period as a plain number
    int  m_cfg_lin, m_cfg_n, m_cfg_m, m_pol, m_cnt;
    logic m_sclk, m_lead, m_trail;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg_lin = 0; m_cfg_n = 0; m_cfg_m = 0; m_pol = 0; m_cnt = 0;
            m_sclk = 0; m_lead = 0; m_trail = 0;
        end else begin
            m_lead = 0; m_trail = 0;
            if (!run) begin
                m_cfg_lin = clk_ctl[12]; m_cfg_n = clk_ctl[7:0]; m_cfg_m = clk_ctl[11:8];
                m_pol = cpol; m_sclk = cpol; m_cnt = 0;
            end else begin
                int half;
                half = m_cfg_lin ? m_cfg_n + 1 : (1 << m_cfg_m);
                if (m_cnt == half - 1) begin
                    m_cnt = 0;
                    if (m_sclk == m_pol) m_lead = 1; else m_trail = 1;
                    m_sclk = ~m_sclk;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) chk({cur_req, " per-cycle outputs"}, {sclk, lead_stb, trail_stb},
                       {m_sclk, m_lead, m_trail});
    end

    // Raise run and count cycles up to the first leading strobe
    task automatic first_toggle(string req, int exp);
        int n = 0;
        @(negedge clk);
        run = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!lead_stb && n < 70000);
        chk({req, " first toggle delay"}, n, exp);
    endtask

    // Count cycles between consecutive leading strobes; one trailing strobe between them
    task automatic period(string req, int exp);
        int n = 0;
        int t = 0;
        while (!lead_stb) @(negedge clk);
        do begin
            @(negedge clk);
            n++;
            if (trail_stb) t++;
        end while (!lead_stb && n < 70000);
        chk({req, " period"}, n, exp);
        chk({req, " trailing strobes per period (R6)"}, t, 1);
    endtask

    task automatic stop_idle(int cycles);
        @(negedge clk);
        run = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset sclk/strobes", {sclk, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {sclk, lead_stb, trail_stb}, 0);

        // R2: idle follows cpol, no strobes
        cur_req = "R2";
        cpol = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 idle level high", sclk, 1);
        cpol = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 idle level low", sclk, 0);

        // R3/R5: linear N=2
        cur_req = "R3";
        clk_ctl = lin_cfg(2);
        @(negedge clk);
        first_toggle("R5 linear N=2", 3);
        period("R3 linear N=2", 6);
        stop_idle(2);

        // R4: power-of-two M=3, idle high
        cur_req = "R4";
        clk_ctl = exp_cfg(3); cpol = 1'b1;
        @(negedge clk);
        first_toggle("R4 exp M=3", 8);
        chk("R6 lead moves away from idle", sclk, 0);
        period("R4 exp M=3", 16);
        stop_idle(2);
        cpol = 1'b0;

        // R8: extremes
        cur_req = "R8";
        clk_ctl = lin_cfg(0);
        @(negedge clk);
        first_toggle("R8 N=0", 1);
        period("R8 N=0", 2);
        stop_idle(2);
        clk_ctl = lin_cfg(255);
        @(negedge clk);
        first_toggle("R8 N=255", 256);
        period("R8 N=255", 512);
        stop_idle(2);
        clk_ctl = exp_cfg(15);
        @(negedge clk);
        first_toggle("R8 M=15", 32768);
        stop_idle(2);

        // R7: mid-burst write deferred
        cur_req = "R7";
        clk_ctl = lin_cfg(1);
        @(negedge clk);
        first_toggle("R7 before write", 2);
        clk_ctl = lin_cfg(5); cpol = 1'b1;
        period("R7 old setting kept", 4);
        stop_idle(1);
        first_toggle("R7 new setting applied", 6);
        stop_idle(2);
        cpol = 1'b0;

        // R9: abort mid half period, restart from zero
        cur_req = "R9";
        clk_ctl = lin_cfg(9);
        @(negedge clk);
        first_toggle("R9 first burst", 10);
        repeat (4) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk("R9 sclk idle after abort", sclk, 0);
        first_toggle("R9 fresh count", 10);
        stop_idle(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule